// File: doc/BRIEF.md
# Lifecycle Debug Access Gate

This block decides, once per power cycle, whether the external test port, the on-chip debug module interface and halt-on-reset may be used. It classifies a 32-bit lifecycle word into development, production, return or invalid. It then derives three permissions from that class, from three policy bits and from an attestation pass flag. The inputs are sampled on a single commit pulse, which boot firmware issues just before it hands control to the next stage. After that pulse the decisions are frozen until reset, so no later software can widen them.

In the return lifecycle the gate first raises a key-erase request and holds it until the erase is acknowledged. It then waits for the attestation pass flag and only after that opens the test port and the debug interface. Halt-on-reset is never granted in the return lifecycle. Until the first commit, every output is denied.

The controller is a four-state machine:
- IDLE: after reset, waiting for the commit pulse.
- ERASE: the key-erase request is driven, waiting for its acknowledge.
- ATTEST: the erase is done, waiting for the attestation pass flag.
- SEALED: the decisions are final.

Its transitions are:
- IDLE to SEALED on a commit with a non-return lifecycle. The permissions are latched in the same cycle.
- IDLE to ERASE on a commit with the return lifecycle.
- ERASE to ATTEST when the erase acknowledge is seen.
- ATTEST to SEALED when the attestation pass flag is seen. The test port and the debug interface are granted in that cycle.
- SEALED stays in SEALED until reset.

Top module: `dbg_access_gate`

## Requirements
- R1: From reset until a commit pulse takes effect, the outputs `jtag_en`, `dmi_en`, `halt_en` and `erase_req` are all 0.
- R2: A commit with `lc_word` = 32'hA5A5_A5A5 (development) sets all three enables to 1 from the cycle after the commit edge. `erase_req` stays 0.
- R3: A commit with `lc_word` = 32'h5A5A_5A5A (production) sets the enables from `dbg_policy`: `jtag_en` from bit 0, `dmi_en` from bit 1 and `halt_en` from bit 2.
- R4: A commit with `lc_word` = 32'h0000_0000 (return) raises `erase_req` from the next cycle. `erase_req` stays high until the edge at which `erase_ack` is sampled high. It is never raised for any other lifecycle.
- R5: In the return lifecycle, once the erase has been acknowledged, `jtag_en` and `dmi_en` become 1 only after `attest_pass` is sampled high. `halt_en` stays 0 at all times.
- R6: In the return lifecycle, no enable is 1 in the cycle right after the acknowledge edge. Enables appear one cycle later at the earliest.
- R7: A commit with any other lifecycle value, including 32'hFFFF_FFFF, leaves every enable at 0.
- R8: Once the decisions are sealed, changes on `lc_word`, `dbg_policy` and `attest_pass`, and further commit pulses, do not change any output until reset.
- R9: In the return lifecycle, `attest_pass` held high before the erase acknowledge grants nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lc_word | input | 32 | Lifecycle word read from fuses |
| dbg_policy | input | 3 | Policy bits: 0 test port, 1 debug interface, 2 halt-on-reset |
| attest_pass | input | 1 | Attestation challenge passed |
| commit | input | 1 | One-cycle pulse that samples the inputs and starts the decision |
| erase_ack | input | 1 | Key-erase latch has been written |
| jtag_en | output | 1 | External test port permitted |
| dmi_en | output | 1 | Debug module interface permitted |
| halt_en | output | 1 | Halt-on-reset permitted |
| erase_req | output | 1 | Request to set the key-erase latch |

## Verification
The assertions check several properties on every cycle:
- Outputs stay quiet before the commit.
- Once sealed, the machine stays sealed and its permissions stay stable.
- `halt_en` is never granted in the return lifecycle.
- The erase request appears only in the return lifecycle.
- No return-lifecycle enable appears unless the erase acknowledge was seen.
- An invalid lifecycle never yields a permission.

Only the bench scenarios can show the rest. They show the exact mapping of each policy bit and the cycle in which each output changes. They also show that a held `attest_pass` grants nothing before the acknowledge, and that late changes on the inputs really have no effect at the ports.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;

    parameter int unsigned LC_WIDTH  = 32;
    parameter int unsigned POL_WIDTH = 3;

    parameter logic [LC_WIDTH-1:0] LC_CODE_DEV  = 32'hA5A5_A5A5;
    parameter logic [LC_WIDTH-1:0] LC_CODE_PROD = 32'h5A5A_5A5A;
    parameter logic [LC_WIDTH-1:0] LC_CODE_RTN  = 32'h0000_0000;

    typedef enum logic [1:0] {
        LC_DEV,
        LC_PROD,
        LC_RTN,
        LC_BAD
    } lc_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ERASE,
        ST_ATTEST,
        ST_SEALED
    } gate_state_e;

    typedef struct packed {
        logic jtag;
        logic dmi;
        logic halt;
    } dbg_perm_t;

endpackage

// File: rtl/lc_decode.sv
module lc_decode
    import dbg_gate_pkg::*;
#(
    parameter int unsigned          LCW       = LC_WIDTH,
    parameter logic [LCW-1:0]       CODE_DEV  = LC_CODE_DEV,
    parameter logic [LCW-1:0]       CODE_PROD = LC_CODE_PROD,
    parameter logic [LCW-1:0]       CODE_RTN  = LC_CODE_RTN
) (
    input  logic [LCW-1:0] lc_word,
    output lc_class_e      lc_class
);

    // Exact match only: every other word, including unprogrammed fuses, is invalid.
    always_comb begin
        if (lc_word == CODE_DEV) begin
            lc_class = LC_DEV;
        end else if (lc_word == CODE_PROD) begin
            lc_class = LC_PROD;
        end else if (lc_word == CODE_RTN) begin
            lc_class = LC_RTN;
        end else begin
            lc_class = LC_BAD;
        end
    end

endmodule

// File: rtl/perm_calc.sv
module perm_calc
    import dbg_gate_pkg::*;
#(
    parameter int unsigned PW       = POL_WIDTH,
    parameter int unsigned JTAG_BIT = 0,
    parameter int unsigned DMI_BIT  = 1,
    parameter int unsigned HALT_BIT = 2
) (
    input  lc_class_e       lc_class,
    input  logic [PW-1:0]   policy,
    input  logic            attest_ok,
    output dbg_perm_t       perm
);

    always_comb begin
        perm = '0;
        unique case (lc_class)
            LC_DEV: begin
                perm.jtag = 1'b1;
                perm.dmi  = 1'b1;
                perm.halt = 1'b1;
            end
            LC_PROD: begin
                perm.jtag = policy[JTAG_BIT];
                perm.dmi  = policy[DMI_BIT];
                perm.halt = policy[HALT_BIT];
            end
            LC_RTN: begin
                // Halt-on-reset is never granted here.
                perm.jtag = attest_ok;
                perm.dmi  = attest_ok;
                perm.halt = 1'b0;
            end
            LC_BAD: begin
                perm = '0;
            end
        endcase
    end

endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
    import dbg_gate_pkg::*;
#(
    parameter int unsigned PW = POL_WIDTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic          erase_ack,
    input  logic          attest_pass,
    input  lc_class_e     live_class,
    input  logic [PW-1:0] live_policy,
    input  dbg_perm_t     perm_next,
    output lc_class_e     eff_class,
    output logic [PW-1:0] eff_policy,
    output dbg_perm_t     perm_q,
    output logic          erase_req
);

    gate_state_e   state, state_nx;
    lc_class_e     cls_q;
    logic [PW-1:0] pol_q;
    logic          erase_seen;

    // Before the commit the live inputs feed the calculator; afterwards the latched copies do.
    assign eff_class  = (state == ST_IDLE) ? live_class  : cls_q;
    assign eff_policy = (state == ST_IDLE) ? live_policy : pol_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (commit) begin
                    state_nx = (live_class == LC_RTN) ? ST_ERASE : ST_SEALED;
                end
            end
            ST_ERASE: begin
                if (erase_ack) begin
                    state_nx = ST_ATTEST;
                end
            end
            ST_ATTEST: begin
                if (attest_pass) begin
                    state_nx = ST_SEALED;
                end
            end
            ST_SEALED: begin
                state_nx = ST_SEALED;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cls_q      <= LC_BAD;
            pol_q      <= '0;
            erase_seen <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && commit) begin
                cls_q <= live_class;
                pol_q <= live_policy;
            end
            if (state == ST_ERASE && erase_ack) begin
                erase_seen <= 1'b1;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perm_q    <= '0;
            erase_req <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (commit) begin
                        if (live_class == LC_RTN) begin
                            erase_req <= 1'b1;
                        end else begin
                            perm_q <= perm_next;
                        end
                    end
                end
                ST_ERASE: begin
                    if (erase_ack) begin
                        erase_req <= 1'b0;
                    end
                end
                ST_ATTEST: begin
                    if (attest_pass) begin
                        perm_q <= perm_next;
                    end
                end
                ST_SEALED: begin
                    perm_q    <= perm_q;
                    erase_req <= 1'b0;
                end
            endcase
        end
    end

    assert_quiet_before_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (perm_q == '0 && !erase_req));

    assert_erase_only_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (cls_q == LC_RTN));

    assert_no_halt_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q == LC_RTN) |-> !perm_q.halt);

    assert_erase_before_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q == LC_RTN && (perm_q.jtag || perm_q.dmi)) |-> erase_seen);

    assert_bad_denies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cls_q == LC_BAD) |-> (perm_q == '0));

    assert_sealed_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEALED) |=> (state == ST_SEALED && $stable(perm_q) && !erase_req));

endmodule

// File: rtl/dbg_access_gate.sv
module dbg_access_gate
    import dbg_gate_pkg::*;
#(
    parameter int unsigned LCW = LC_WIDTH,
    parameter int unsigned PW  = POL_WIDTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LCW-1:0] lc_word,
    input  logic [PW-1:0]  dbg_policy,
    input  logic           attest_pass,
    input  logic           commit,
    input  logic           erase_ack,
    output logic           jtag_en,
    output logic           dmi_en,
    output logic           halt_en,
    output logic           erase_req
);

    lc_class_e     live_class;
    lc_class_e     eff_class;
    logic [PW-1:0] eff_policy;
    dbg_perm_t     perm_next;
    dbg_perm_t     perm_q;

    lc_decode #(.LCW(LCW)) u_decode (
        .lc_word  (lc_word),
        .lc_class (live_class)
    );

    perm_calc #(.PW(PW)) u_calc (
        .lc_class  (eff_class),
        .policy    (eff_policy),
        .attest_ok (attest_pass),
        .perm      (perm_next)
    );

    gate_fsm #(.PW(PW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .erase_ack   (erase_ack),
        .attest_pass (attest_pass),
        .live_class  (live_class),
        .live_policy (dbg_policy),
        .perm_next   (perm_next),
        .eff_class   (eff_class),
        .eff_policy  (eff_policy),
        .perm_q      (perm_q),
        .erase_req   (erase_req)
    );

    assign jtag_en = perm_q.jtag;
    assign dmi_en  = perm_q.dmi;
    assign halt_en = perm_q.halt;

endmodule

// File: tb/test_dbg_access_gate.sv
module test_dbg_access_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lc_word = 32'hFFFF_FFFF;
    logic [2:0]  dbg_policy = '0;
    logic        attest_pass = 1'b0;
    logic        commit = 1'b0;
    logic        erase_ack = 1'b0;
    logic        jtag_en, dmi_en, halt_en, erase_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] v;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    dbg_access_gate i_dbg_access_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .lc_word     (lc_word),
        .dbg_policy  (dbg_policy),
        .attest_pass (attest_pass),
        .commit      (commit),
        .erase_ack   (erase_ack),
        .jtag_en     (jtag_en),
        .dmi_en      (dmi_en),
        .halt_en     (halt_en),
        .erase_req   (erase_req)
    );

    // Monitor: compares outputs {jtag,dmi,halt,erase} at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            logic [3:0] act;
            e = sb_q.pop_front();
            act = {jtag_en, dmi_en, halt_en, erase_req};
            checks++;
            if (act !== e.v) begin
                errors++;
                $display("FAIL %s: got %b expected %b", e.tag, act, e.v);
            end
        end
    end

    // Driver: lets one rising edge pass, queues the expected outputs, returns at the falling edge
    task automatic tick_expect(input logic [3:0] e, input string tag);
        @(posedge clk);
        #1;
        sb_q.push_back('{e, tag});
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        commit = 1'b0;
        erase_ack = 1'b0;
        attest_pass = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic commit_expect(input logic [31:0] lc, input logic [2:0] pol,
                                 input logic [3:0] e, input string tag);
        do_reset();
        lc_word = lc;
        dbg_policy = pol;
        commit = 1'b1;
        tick_expect(e, tag);
        commit = 1'b0;
        tick_expect(e, tag);
    endtask

    initial begin
        do_reset();
        tick_expect(4'b0000, "R1 reset");
        tick_expect(4'b0000, "R1 no commit");

        commit_expect(32'hA5A5_A5A5, 3'b000, 4'b1110, "R2 dev");
        // Sealed: later input changes and commits are ignored
        lc_word = 32'h5A5A_5A5A;
        dbg_policy = 3'b000;
        commit = 1'b1;
        tick_expect(4'b1110, "R8 recommit");
        commit = 1'b0;
        lc_word = 32'h0000_0000;
        attest_pass = 1'b1;
        tick_expect(4'b1110, "R8 lc change");

        commit_expect(32'h5A5A_5A5A, 3'b101, 4'b1010, "R3 prod 101");
        commit_expect(32'h5A5A_5A5A, 3'b010, 4'b0100, "R3 prod 010");
        commit_expect(32'h5A5A_5A5A, 3'b000, 4'b0000, "R3 prod 000");
        dbg_policy = 3'b111;
        tick_expect(4'b0000, "R8 policy change");

        commit_expect(32'hFFFF_FFFF, 3'b111, 4'b0000, "R7 all ones");
        commit_expect(32'h1234_5678, 3'b111, 4'b0000, "R7 random");

        // Return lifecycle with attestation held high from the start
        do_reset();
        lc_word = 32'h0000_0000;
        dbg_policy = 3'b111;
        attest_pass = 1'b1;
        commit = 1'b1;
        tick_expect(4'b0001, "R4 erase req");
        commit = 1'b0;
        tick_expect(4'b0001, "R9 held attest no ack");
        tick_expect(4'b0001, "R4 erase held");
        erase_ack = 1'b1;
        tick_expect(4'b0000, "R6 ack cycle");
        erase_ack = 1'b0;
        tick_expect(4'b1100, "R5 unlock after attest");
        attest_pass = 1'b0;
        lc_word = 32'hA5A5_A5A5;
        commit = 1'b1;
        tick_expect(4'b1100, "R8 return sealed");
        commit = 1'b0;

        // Return lifecycle without attestation
        do_reset();
        lc_word = 32'h0000_0000;
        commit = 1'b1;
        tick_expect(4'b0001, "R4 erase req 2");
        commit = 1'b0;
        erase_ack = 1'b1;
        tick_expect(4'b0000, "R6 ack no enable");
        erase_ack = 1'b0;
        tick_expect(4'b0000, "R5 no attest");
        tick_expect(4'b0000, "R5 still locked");
        attest_pass = 1'b1;
        tick_expect(4'b1100, "R5 late attest");

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule